// File: doc/BRIEF.md
# Predicated Paired-Doubleword Interleaving Store

This block stores two vector sources of 64-bit elements to memory as an array of two-field records. Element i of the first source and element i of the second source land side by side: the first-source doubleword at the lower address, the second-source doubleword eight bytes above it. One predicate bit per element index decides whether that record is written at all. A record whose bit is clear produces no write request on the memory port, so it can never fault, and the memory it covers is left as it was.

A one-cycle `start` pulse captures both vectors, the predicate, a 64-bit base and a 5-bit signed immediate. The immediate is scaled by the vector length in bytes and added to the base. Writes then leave through a 64-bit valid/ready port, one doubleword per accepted handshake, in ascending address order. Inactive records cost no cycles. A per-write error flag returned with the handshake stops the operation at once and reports which element faulted. The vector length is a build-time parameter from 128 to 2048 bits.

Top module: `pair_store_unit`

## Requirements
- R1: For every active element i, the first-source doubleword is written to `start + 16*i` and the second-source doubleword is written to `start + 16*i + 8` on the next accepted handshake after it.
- R2: The start address is `baseAddr + offsetImm * (VEC_BITS/8)`, where `offsetImm` is read as a 5-bit two's-complement value and the sum wraps modulo 2^64.
- R3: Writes leave in ascending element order. Inactive elements issue no request and spend no cycle. With `memReady` held high, each write occupies exactly one cycle and `done` pulses on the cycle after the last accepted write.
- R4: Element i is active when bit `8*i` of `predMask` is 1. Every other `predMask` bit has no effect.
- R5: When no element is active, `done` pulses on the cycle after `start` and no write is issued.
- R6: An odd `offsetImm` raises `illegal` together with a `done` pulse on the cycle after `start`, and no write is issued.
- R7: A write accepted with `memErr` high ends the operation. No further write follows, `done` and `fault` are high on the next cycle, and `faultIndex` gives the element index of the faulting write.
- R8: A `start` pulse while `busy` is high is ignored. The running operation completes with its captured operands.
- R9: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memData` hold steady.
- R10: After reset, `busy`, `memValid`, `done`, `fault` and `illegal` are low.
- R11: `fault`, `illegal` and `faultIndex` keep their values after the `done` pulse until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request that captures the operands |
| srcA | input | VEC_BITS | First-field vector; element i in bits 64*i+63..64*i |
| srcB | input | VEC_BITS | Second-field vector, same layout |
| predMask | input | VEC_BITS/8 | Predicate, one bit per byte; bit 8*i enables element i |
| baseAddr | input | 64 | Base byte address |
| offsetImm | input | 5 | Signed immediate, scaled by vector bytes |
| busy | output | 1 | An operation is issuing writes |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last operation ended on a memory error |
| illegal | output | 1 | Last operation was rejected for an odd immediate |
| faultIndex | output | clog2(VEC_BITS/64) | Element index of the faulting write |
| memValid | output | 1 | Write request valid |
| memAddr | output | 64 | Write byte address |
| memData | output | 64 | Write data |
| memReady | input | 1 | Memory accepts the request this cycle |
| memErr | input | 1 | Error for the write accepted this cycle |

## Verification
The first write request appears on the cycle after the `start` edge, and each later one follows the edge that accepted its predecessor. `done`, together with `fault` or `illegal`, arrives one cycle after the final accepted write, after the error handshake, or after `start` itself for rejected or empty operations. The bench drives inputs and samples outputs on the falling edge. It checks the presented address and data on every cycle in which `memValid` is high, stalled cycles included, and counts falling edges from `start` to `done`, comparing that count with 2·(active elements)+1 when there is no back-pressure. A sweep covers every predicate pattern of a four-element build, several immediates, an error at each write position, and a `start` injected mid-operation.

// File: rtl/pst_pkg.sv
package pst_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture operands, point at first active element
    logic stepHalf;  // move from first field to second field
    logic stepElem;  // move to next active element, first field
  } pst_ctl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pst_state_t;
endpackage

// File: rtl/pst_datapath.sv
module pst_datapath
  import pst_pkg::*;
#(
  parameter int VEC_BITS = 512,
  localparam int ELEMS = VEC_BITS / 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int SHIFT = $clog2(VEC_BITS / 8)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pst_ctl_t              ctl,
  input  logic [VEC_BITS-1:0]   srcA,
  input  logic [VEC_BITS-1:0]   srcB,
  input  logic [VEC_BITS/8-1:0] predMask,
  input  logic [63:0]           baseAddr,
  input  logic [4:0]            offsetImm,
  output logic [63:0]           memAddr,
  output logic [63:0]           memData,
  output logic [IDX_W-1:0]      curIdx,
  output logic                  onSecond,
  output logic                  firstValid,
  output logic                  nextValid
);
  logic [ELEMS-1:0][63:0] vecA, vecB;
  logic [ELEMS-1:0]       inMask, actMask;
  logic [63:0]            startAddr, scaledOff;
  logic [IDX_W-1:0]       firstIdx, nextIdx;

  // one enable bit per element: lowest bit of each byte group
  for (genvar g = 0; g < ELEMS; g++) begin : gPick
    assign inMask[g] = predMask[8*g];
  end

  assign scaledOff = {{59{offsetImm[4]}}, offsetImm} << SHIFT;

  always_comb begin
    firstValid = 1'b0;
    firstIdx   = '0;
    for (int i = ELEMS - 1; i >= 0; i--) begin
      if (inMask[i]) begin
        firstValid = 1'b1;
        firstIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    nextValid = 1'b0;
    nextIdx   = '0;
    for (int i = ELEMS - 1; i >= 0; i--) begin
      if (actMask[i] && (i > int'(curIdx))) begin
        nextValid = 1'b1;
        nextIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMask   <= '0;
      curIdx    <= '0;
      onSecond  <= 1'b0;
      startAddr <= '0;
    end else if (ctl.load) begin
      actMask   <= inMask;
      curIdx    <= firstIdx;
      onSecond  <= 1'b0;
      startAddr <= baseAddr + scaledOff;
    end else if (ctl.stepHalf) begin
      onSecond  <= 1'b1;
    end else if (ctl.stepElem) begin
      curIdx    <= nextIdx;
      onSecond  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      vecA <= srcA;
      vecB <= srcB;
    end
  end

  assign memAddr = startAddr + 64'({curIdx, onSecond, 3'b000});
  assign memData = onSecond ? vecB[curIdx] : vecA[curIdx];
endmodule

// File: rtl/pst_control.sv
module pst_control
  import pst_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             immOdd,
  input  logic             firstValid,
  input  logic             nextValid,
  input  logic             onSecond,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             memReady,
  input  logic             memErr,
  output pst_ctl_t         ctl,
  output logic             busy,
  output logic             memValid,
  output logic             done,
  output logic             fault,
  output logic             illegal,
  output logic [IDX_W-1:0] faultIndex
);
  pst_state_t state;
  logic       accept, okBeat;

  assign busy     = (state == ST_RUN);
  assign memValid = busy;
  assign accept   = (state == ST_IDLE) && start;
  assign okBeat   = busy && memReady && !memErr;

  always_comb begin
    ctl          = '0;
    ctl.load     = accept;
    ctl.stepHalf = okBeat && !onSecond;
    ctl.stepElem = okBeat && onSecond && nextValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      fault      <= 1'b0;
      illegal    <= 1'b0;
      faultIndex <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        fault      <= 1'b0;
        illegal    <= immOdd;
        faultIndex <= '0;
        if (immOdd || !firstValid) done  <= 1'b1;
        else                       state <= ST_RUN;
      end else if (busy && memReady) begin
        if (memErr) begin
          fault      <= 1'b1;
          faultIndex <= curIdx;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end else if (onSecond && !nextValid) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/pair_store_unit.sv
module pair_store_unit
  import pst_pkg::*;
#(
  parameter int VEC_BITS = 512,
  localparam int ELEMS = VEC_BITS / 64,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [VEC_BITS-1:0]   srcA,
  input  logic [VEC_BITS-1:0]   srcB,
  input  logic [VEC_BITS/8-1:0] predMask,
  input  logic [63:0]           baseAddr,
  input  logic [4:0]            offsetImm,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic                  illegal,
  output logic [IDX_W-1:0]      faultIndex,
  output logic                  memValid,
  output logic [63:0]           memAddr,
  output logic [63:0]           memData,
  input  logic                  memReady,
  input  logic                  memErr
);
  pst_ctl_t         ctl;
  logic [IDX_W-1:0] curIdx;
  logic             onSecond, firstValid, nextValid;

  pst_datapath #(.VEC_BITS(VEC_BITS)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcA(srcA), .srcB(srcB), .predMask(predMask),
    .baseAddr(baseAddr), .offsetImm(offsetImm),
    .memAddr(memAddr), .memData(memData),
    .curIdx(curIdx), .onSecond(onSecond),
    .firstValid(firstValid), .nextValid(nextValid)
  );

  pst_control #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .immOdd(offsetImm[0]),
    .firstValid(firstValid), .nextValid(nextValid),
    .onSecond(onSecond), .curIdx(curIdx),
    .memReady(memReady), .memErr(memErr),
    .ctl(ctl), .busy(busy), .memValid(memValid), .done(done),
    .fault(fault), .illegal(illegal), .faultIndex(faultIndex)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        illegal,
  input logic        memValid,
  input logic [63:0] memAddr,
  input logic [63:0] memData,
  input logic        memReady,
  input logic        memErr
);
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  a_r7_stop_on_error: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && memErr |=> !memValid && done && fault);

  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !memValid);

  a_r3_done_after_writes: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memValid && !busy);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !memReady |=> busy);

  a_r11_fault_held: assert property (@(posedge clk) disable iff (!rstN)
    fault && !start |=> fault);
endmodule

bind pair_store_unit pst_checker uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .fault(fault), .illegal(illegal), .memValid(memValid),
  .memAddr(memAddr), .memData(memData),
  .memReady(memReady), .memErr(memErr)
);

// File: tb/pair_store_unit_test.sv
module pair_store_unit_test;
  localparam int VB = 256;
  localparam int NE = VB / 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [VB-1:0] srcA = '0, srcB = '0;
  logic [VB/8-1:0] predMask = '0;
  logic [63:0]   baseAddr = '0;
  logic [4:0]    offsetImm = '0;
  logic          busy, done, fault, illegal, memValid;
  logic [1:0]    faultIndex;
  logic [63:0]   memAddr, memData;
  logic          memReady = 1'b0, memErr = 1'b0;

  int checks = 0, errors = 0, opNum = 0, cycles = 0;

  always #5 clk = ~clk;

  pair_store_unit #(.VEC_BITS(VB)) uut (
    .clk(clk), .rstN(rstN), .start(start), .srcA(srcA), .srcB(srcB),
    .predMask(predMask), .baseAddr(baseAddr), .offsetImm(offsetImm),
    .busy(busy), .done(done), .fault(fault), .illegal(illegal),
    .faultIndex(faultIndex), .memValid(memValid), .memAddr(memAddr),
    .memData(memData), .memReady(memReady), .memErr(memErr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not end, cycles %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] elemA(int op, int i);
    return 64'hA000_0000_0000_0000 | (64'(op) << 16) | 64'(i);
  endfunction
  function automatic logic [63:0] elemB(int op, int i);
    return 64'hB000_0000_0000_0000 | (64'(op) << 16) | 64'(i);
  endfunction

  // m: element enables; imm: even immediate; stall: back-pressure; junk: set
  // non-enable predicate bits; errAt: write number that errors (-1 none);
  // poke: pulse start mid-operation
  task automatic runOp(input logic [NE-1:0] m, input int imm, input bit stall,
                       input bit junk, input logic [63:0] base, input int errAt,
                       input bit poke);
    logic [63:0] expAddr[2*NE];
    logic [63:0] expData[2*NE];
    int          actIdx[NE];
    int          nAct = 0, expW, wCnt = 0, cyc = 1;
    bit          gotDone = 0;
    logic [63:0] st;
    opNum++;
    st = base + 64'(longint'(imm) * (VB / 8));
    for (int i = 0; i < NE; i++) begin
      if (m[i]) begin
        actIdx[nAct] = i;
        expAddr[2*nAct]   = st + 64'(16 * i);
        expData[2*nAct]   = elemA(opNum, i);
        expAddr[2*nAct+1] = st + 64'(16 * i + 8);
        expData[2*nAct+1] = elemB(opNum, i);
        nAct++;
      end
    end
    expW = (errAt >= 0) ? errAt + 1 : 2 * nAct;
    for (int i = 0; i < NE; i++) begin
      srcA[64*i +: 64] = elemA(opNum, i);
      srcB[64*i +: 64] = elemB(opNum, i);
    end
    predMask = junk ? {(VB/8/8){8'hFE}} : '0;
    for (int i = 0; i < NE; i++) predMask[8*i] = m[i];
    baseAddr  = base;
    offsetImm = 5'(imm);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!gotDone && cyc < 200) begin
      if (done) begin
        gotDone  = 1;
        memReady = 1'b0;
        memErr   = 1'b0;
      end else begin
        if (poke && cyc == 2) begin
          start = 1'b1; predMask = '1; offsetImm = 5'd1; baseAddr = 64'h0;
        end else start = 1'b0;
        if (memValid) begin
          check(wCnt < expW, "R3 no write beyond expected count", 64'(wCnt), 64'(expW));
          if (wCnt < expW) begin
            check(memAddr == expAddr[wCnt], "R1/R2 write address", memAddr, expAddr[wCnt]);
            check(memData == expData[wCnt], "R1 write data order", memData, expData[wCnt]);
          end
          memReady = stall ? ((cyc % 3) != 0) : 1'b1;
          memErr   = memReady && (wCnt == errAt);
          if (memReady) wCnt++;
        end else begin
          memReady = 1'b0;
          memErr   = 1'b0;
        end
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    check(gotDone, "R3 done reached", 64'(gotDone), 64'd1);
    check(wCnt == expW, "R3 R4 write count", 64'(wCnt), 64'(expW));
    check(fault == (errAt >= 0), "R7 fault flag", 64'(fault), 64'(errAt >= 0));
    check(!illegal, "R6 illegal low for even immediate", 64'(illegal), 64'd0);
    if (errAt >= 0)
      check(faultIndex == 2'(actIdx[errAt/2]), "R7 fault index", 64'(faultIndex), 64'(actIdx[errAt/2]));
    if (!stall && errAt < 0 && !poke)
      check(cyc == 2 * nAct + 1, (nAct == 0) ? "R5 done one cycle after start" : "R3 done timing",
            64'(cyc), 64'(2 * nAct + 1));
    @(negedge clk);
    check(!memValid && !done, "R7 R8 quiet after done", {62'd0, memValid, done}, 64'd0);
    check(fault == (errAt >= 0), "R11 fault held", 64'(fault), 64'(errAt >= 0));
  endtask

  task automatic runIllegal(input int imm, input logic [NE-1:0] m);
    int cyc = 1;
    bit sawValid = 0;
    predMask = '0;
    for (int i = 0; i < NE; i++) predMask[8*i] = m[i];
    offsetImm = 5'(imm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && illegal, "R6 illegal with done next cycle", {62'd0, done, illegal}, 64'd3);
    check(!memValid, "R6 no write on odd immediate", 64'(memValid), 64'd0);
    for (int k = 0; k < 3; k++) begin
      if (memValid) sawValid = 1;
      @(negedge clk);
    end
    check(!sawValid, "R6 no write afterwards", 64'(sawValid), 64'd0);
    check(illegal, "R11 illegal held", 64'(illegal), 64'd1);
  endtask

  initial begin
    int imms[4] = '{-16, 0, 6, 14};
    repeat (3) @(negedge clk);
    check(!busy && !memValid && !done && !fault && !illegal, "R10 reset state",
          {59'd0, busy, memValid, done, fault, illegal}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // sweep every predicate pattern, immediates, stall and junk bits
    for (int m = 0; m < (1 << NE); m++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 2; s++)
          runOp(NE'(m), imms[k], s[0], s[0], 64'h0000_0000_8000_0000 + 64'(m * 4096), -1, 0);
    // address wrap
    runOp(4'b1001, 2, 0, 0, 64'hFFFF_FFFF_FFFF_FFE0, -1, 0);  // R2
    runOp(4'b0110, -2, 1, 0, 64'h0000_0000_0000_0020, -1, 0); // R2
    // only non-enable bits set: nothing written (R4)
    runOp(4'b0000, 0, 0, 1, 64'h1000, -1, 0);
    // error at every write position (R7)
    for (int e = 0; e < 6; e++) runOp(4'b1011, 4, 0, 0, 64'h4000, e, 0);
    runOp(4'b1110, 0, 1, 0, 64'h4000, 3, 0);
    // start while busy ignored (R8)
    runOp(4'b1111, 0, 0, 0, 64'h9000, -1, 1);
    runOp(4'b0101, -4, 1, 1, 64'h9000, -1, 1);
    // odd immediates (R6), then flags cleared by next start (R11)
    runIllegal(1, 4'b1111);
    runIllegal(-1, 4'b0001);
    runIllegal(13, 4'b0000);
    runOp(4'b0010, 2, 0, 0, 64'h2000, -1, 0);
    check(!illegal, "R11 illegal cleared by next start", 64'(illegal), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule